// File: doc/BRIEF.md
# Priority Interrupt Controller with Non-Maskable Input

This block gathers interrupt requests from five classes of source and picks the one the CPU should take next. The classes are a non-maskable pin, a user-break match, a debug-port request, a set of external request lines, and a set of on-chip peripheral requests. Every request carries a priority level on a 0-to-16 scale. The winner is compared with the CPU's current 4-bit interrupt mask. The non-maskable pin sits at level 16 and gets through whatever the mask is. The break and debug requests are fixed at level 15. External and peripheral lines take their level from a 4-bit priority field, and a field of 0 keeps that line shut off for good.

Once a request is accepted, the block raises `req_valid` and presents two registered values. One is the identifier of the source. The other is the mask level the CPU should load into its status register: 15 for the three fixed sources, and the source's own level for the rest. Both values hold still until the CPU pulses `ack`. The non-maskable pin is edge-detected, and a control input chooses which edge counts. The debug request is caught on its rising edge. Both of these edge-caught requests stay pending until the CPU acknowledges that particular source.

Top module: `prio_intc`

## Requirements
- R1: After a synchronous reset, `req_valid` is 0 and no request is offered until an input calls for one.
- R2: An external or peripheral line is accepted only when its priority field is strictly greater than `cur_mask`. A field of 0, or a field equal to the mask, is never accepted.
- R3: A pending non-maskable request is accepted even when `cur_mask` is 15, and the mask level it presents is 15.
- R4: When `nmi_rise_sel` is 1, a 0-to-1 transition of `nmi_pin` makes a non-maskable request pending. When it is 0, a 1-to-0 transition does so. The opposite transition has no effect in either case.
- R5: The user-break request has level 15. It is accepted only while `cur_mask` is below 15, and it presents a mask level of 15.
- R6: A rising edge on `dbg_req` stays pending while it is masked, including after the input has returned low. It is accepted once `cur_mask` drops below 15, and it presents a mask level of 15.
- R7: An accepted external or peripheral line presents its own priority field as the new mask level.
- R8: Among eligible requests, the one with the highest level wins.
- R9: Ties at equal level go to the lower source identifier. Identifiers are: 0 for the non-maskable pin, 1 for user break, 2 for debug, 3+i for external line i, and 3+N_IRQ+j for peripheral j.
- R10: An acknowledge clears a latched non-maskable or debug request only when that source is the one being presented. A latched request survives the acknowledge of a different source.
- R11: While `req_valid` is 1, `req_src` and `req_mask` do not change until `ack`. This holds even if the request that won is withdrawn. In the cycle after `ack`, `req_valid` is 0.
- R12: A level-type request is offered one clock edge after it is applied. An edge-type request is offered two edges after its pin transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_pin | input | 1 | Non-maskable request pin |
| nmi_rise_sel | input | 1 | 1 selects the rising edge of nmi_pin, 0 selects the falling edge |
| ubrk_req | input | 1 | User-break match request (level) |
| dbg_req | input | 1 | Debug-port request, caught on its rising edge |
| irq_req | input | N_IRQ | External request lines (level) |
| irq_prio | input | 4*N_IRQ | Priority field of each external line, line i at bits 4i+3:4i |
| per_req | input | N_PER | Peripheral request lines (level) |
| per_prio | input | 4*N_PER | Priority field of each peripheral, peripheral j at bits 4j+3:4j |
| cur_mask | input | 4 | CPU's current interrupt mask level |
| ack | input | 1 | CPU acknowledge of the presented request |
| req_valid | output | 1 | A request is being presented |
| req_src | output | ID_W | Identifier of the presented source |
| req_mask | output | 4 | Mask level for the CPU to load on acceptance |

## Verification
The bench builds the block with N_IRQ=4 and N_PER=4. With so few lines, three requests at the same level can be placed in different classes, which exercises the tie order across class boundaries. It also lets the peripheral identifier range, 7 to 10, be checked against the R9 numbering. A behavioural model that treats each source as a simple integer level is compared with the outputs on every clock. Directed sequences then exercise the mask boundary, both edge polarities of the non-maskable pin, and a debug request that is held back by the mask before it is accepted.

// File: rtl/intc_pkg.sv
package intc_pkg;
  // Width of the CPU mask field and of each programmable priority field
  localparam int PRIO_W   = 4;
  // Internal level width, wide enough to carry the top level 16
  localparam int LVL_W    = PRIO_W + 1;
  localparam int LVL_NMI  = 16;
  localparam int LVL_FIX  = 15;
  localparam int MASK_MAX = (1 << PRIO_W) - 1;
  // Fixed source numbering; external lines follow, then peripherals
  localparam int SRC_NMI  = 0;
  localparam int SRC_UBRK = 1;
  localparam int SRC_DBG  = 2;
  localparam int SRC_BASE = 3;
endpackage

// File: rtl/intc_edge_latch.sv
module intc_edge_latch (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic rise_sel,
  input  logic clr,
  output logic pend
);
  logic prev_q;
  logic hit;

  always_comb begin
    if (rise_sel) hit = pin & ~prev_q;
    else          hit = ~pin & prev_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      // Take the pin's present value so that reset itself produces no edge
      prev_q <= pin;
      pend   <= 1'b0;
    end else begin
      prev_q <= pin;
      // A new edge in the same cycle as the clear keeps the request pending
      pend   <= (pend & ~clr) | hit;
    end
  end
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
  import intc_pkg::*;
#(
  parameter int NSRC = 11,
  parameter int ID_W = 4
) (
  input  logic [NSRC-1:0]       elig,
  input  logic [NSRC*LVL_W-1:0] lvl,
  output logic                  any,
  output logic [ID_W-1:0]       idx,
  output logic [LVL_W-1:0]      win_lvl
);
  // The scan runs from the highest index down and takes any level that is
  // not lower than the current best, so on a tie the lower index wins.
  always_comb begin
    any     = 1'b0;
    idx     = '0;
    win_lvl = '0;
    for (int k = NSRC - 1; k >= 0; k--) begin
      if (elig[k] && (!any || lvl[k*LVL_W +: LVL_W] >= win_lvl)) begin
        any     = 1'b1;
        idx     = ID_W'(k);
        win_lvl = lvl[k*LVL_W +: LVL_W];
      end
    end
  end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import intc_pkg::*;
#(
  parameter int N_IRQ = 8,
  parameter int N_PER = 16,
  localparam int NSRC = SRC_BASE + N_IRQ + N_PER,
  localparam int ID_W = $clog2(NSRC)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    nmi_pin,
  input  logic                    nmi_rise_sel,
  input  logic                    ubrk_req,
  input  logic                    dbg_req,
  input  logic [N_IRQ-1:0]        irq_req,
  input  logic [N_IRQ*PRIO_W-1:0] irq_prio,
  input  logic [N_PER-1:0]        per_req,
  input  logic [N_PER*PRIO_W-1:0] per_prio,
  input  logic [PRIO_W-1:0]       cur_mask,
  input  logic                    ack,
  output logic                    req_valid,
  output logic [ID_W-1:0]         req_src,
  output logic [PRIO_W-1:0]       req_mask
);
  localparam int PER_BASE = SRC_BASE + N_IRQ;

  logic                  nmi_pend, dbg_pend;
  logic                  nmi_clr, dbg_clr;
  logic [NSRC-1:0]       elig;
  logic [NSRC*LVL_W-1:0] lvl;
  logic                  win_any;
  logic [ID_W-1:0]       win_idx;
  logic [LVL_W-1:0]      win_lvl;
  logic [LVL_W-1:0]      mask_ext;

  assign mask_ext = {1'b0, cur_mask};
  assign nmi_clr  = req_valid & ack & (req_src == ID_W'(SRC_NMI));
  assign dbg_clr  = req_valid & ack & (req_src == ID_W'(SRC_DBG));

  intc_edge_latch u_nmi_edge (
    .clk(clk), .rst(rst), .pin(nmi_pin), .rise_sel(nmi_rise_sel),
    .clr(nmi_clr), .pend(nmi_pend)
  );

  intc_edge_latch u_dbg_edge (
    .clk(clk), .rst(rst), .pin(dbg_req), .rise_sel(1'b1),
    .clr(dbg_clr), .pend(dbg_pend)
  );

  // Fixed sources: the NMI ignores the mask, break and debug sit at level 15
  assign lvl[SRC_NMI*LVL_W  +: LVL_W] = LVL_W'(LVL_NMI);
  assign lvl[SRC_UBRK*LVL_W +: LVL_W] = LVL_W'(LVL_FIX);
  assign lvl[SRC_DBG*LVL_W  +: LVL_W] = LVL_W'(LVL_FIX);
  assign elig[SRC_NMI]  = nmi_pend;
  assign elig[SRC_UBRK] = ubrk_req & (LVL_W'(LVL_FIX) > mask_ext);
  assign elig[SRC_DBG]  = dbg_pend & (LVL_W'(LVL_FIX) > mask_ext);

  // Programmable sources: the strict compare also blocks a level of 0
  for (genvar i = 0; i < N_IRQ; i++) begin : g_irq
    logic [LVL_W-1:0] l;
    assign l = {1'b0, irq_prio[i*PRIO_W +: PRIO_W]};
    assign lvl[(SRC_BASE+i)*LVL_W +: LVL_W] = l;
    assign elig[SRC_BASE+i] = irq_req[i] & (l > mask_ext);
  end

  for (genvar j = 0; j < N_PER; j++) begin : g_per
    logic [LVL_W-1:0] l;
    assign l = {1'b0, per_prio[j*PRIO_W +: PRIO_W]};
    assign lvl[(PER_BASE+j)*LVL_W +: LVL_W] = l;
    assign elig[PER_BASE+j] = per_req[j] & (l > mask_ext);
  end

  intc_arbiter #(.NSRC(NSRC), .ID_W(ID_W)) u_arb (
    .elig(elig), .lvl(lvl), .any(win_any), .idx(win_idx), .win_lvl(win_lvl)
  );

  // Presentation register: loads the winner, then holds it until acknowledged
  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid <= 1'b0;
      req_src   <= '0;
      req_mask  <= '0;
    end else if (req_valid) begin
      if (ack) req_valid <= 1'b0;
    end else if (win_any) begin
      req_valid <= 1'b1;
      req_src   <= win_idx;
      req_mask  <= (win_lvl > LVL_W'(MASK_MAX)) ? PRIO_W'(MASK_MAX)
                                                : win_lvl[PRIO_W-1:0];
    end
  end
endmodule

// File: rtl/intc_checker.sv
module intc_checker
  import intc_pkg::*;
#(
  parameter int ID_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              ack,
  input logic [PRIO_W-1:0] cur_mask,
  input logic              req_valid,
  input logic [ID_W-1:0]   req_src,
  input logic [PRIO_W-1:0] req_mask
);
  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> !req_valid); // R1
  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !ack) |=> (req_valid && $stable(req_src) && $stable(req_mask))); // R11
  AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (rst)
    (req_valid && ack) |=> !req_valid); // R11
  AST_NMI_MASK15: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_src == ID_W'(SRC_NMI)) |-> req_mask == PRIO_W'(LVL_FIX)); // R3
  AST_FIXED_MASK15: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (req_src == ID_W'(SRC_UBRK) || req_src == ID_W'(SRC_DBG)))
      |-> req_mask == PRIO_W'(LVL_FIX)); // R5
  AST_ABOVE_MASK: assert property (@(posedge clk) disable iff (rst)
    ($rose(req_valid) && req_src != ID_W'(SRC_NMI)) |-> req_mask > $past(cur_mask)); // R2
endmodule

bind prio_intc intc_checker #(.ID_W(ID_W)) u_chk (
  .clk(clk), .rst(rst), .ack(ack), .cur_mask(cur_mask),
  .req_valid(req_valid), .req_src(req_src), .req_mask(req_mask)
);

// File: tb/tb_prio_intc.sv
module tb_prio_intc;
  localparam int N_IRQ = 4;
  localparam int N_PER = 4;
  localparam int NS    = 3 + N_IRQ + N_PER;
  localparam int ID_W  = $clog2(NS);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic nmi_pin = 1'b0, nmi_rise_sel = 1'b1, ubrk_req = 1'b0, dbg_req = 1'b0;
  logic [N_IRQ-1:0]   irq_req = '0;
  logic [N_IRQ*4-1:0] irq_prio = '0;
  logic [N_PER-1:0]   per_req = '0;
  logic [N_PER*4-1:0] per_prio = '0;
  logic [3:0] cur_mask = 4'd0;
  logic ack = 1'b0;
  logic req_valid;
  logic [ID_W-1:0] req_src;
  logic [3:0] req_mask;

  int checks = 0, errors = 0;
  bit model_on = 0;

  prio_intc #(.N_IRQ(N_IRQ), .N_PER(N_PER)) dut (
    .clk(clk), .rst(rst), .nmi_pin(nmi_pin), .nmi_rise_sel(nmi_rise_sel),
    .ubrk_req(ubrk_req), .dbg_req(dbg_req), .irq_req(irq_req), .irq_prio(irq_prio),
    .per_req(per_req), .per_prio(per_prio), .cur_mask(cur_mask), .ack(ack),
    .req_valid(req_valid), .req_src(req_src), .req_mask(req_mask)
  );

  always #2.5 clk = ~clk;

  // Behavioural reference: each source is an integer level plus a request bit
  int m_valid = 0, m_src = 0, m_mask = 0, m_np = 0, m_dp = 0, m_pn = 0, m_pd = 0;

  function automatic int src_level(int s);
    if (s == 0) return 16;
    if (s < 3) return 15;
    if (s < 3 + N_IRQ) return int'(irq_prio[(s-3)*4 +: 4]);
    return int'(per_prio[(s-3-N_IRQ)*4 +: 4]);
  endfunction

  function automatic bit src_req(int s);
    if (s == 0) return m_np != 0;
    if (s == 1) return ubrk_req;
    if (s == 2) return m_dp != 0;
    if (s < 3 + N_IRQ) return irq_req[s-3];
    return per_req[s-3-N_IRQ];
  endfunction

  always @(posedge clk) begin
    int best, bl, ne, de, pin, dp;
    pin = int'(nmi_pin); dp = int'(dbg_req);
    if (rst) begin
      m_valid = 0; m_np = 0; m_dp = 0; m_pn = pin; m_pd = dp;
    end else begin
      ne = nmi_rise_sel ? (pin == 1 && m_pn == 0) : (pin == 0 && m_pn == 1);
      de = (dp == 1 && m_pd == 0);
      best = -1; bl = -1;
      if (m_valid == 0) begin
        for (int s = 0; s < NS; s++) begin
          int l;
          l = src_level(s);
          if (src_req(s) && (s == 0 || l > int'(cur_mask)) && l > bl) begin
            best = s; bl = l;
          end
        end
      end
      if (m_valid != 0 && ack) begin
        if (m_src == 0) m_np = 0;
        if (m_src == 2) m_dp = 0;
        m_valid = 0;
      end else if (m_valid == 0 && best >= 0) begin
        m_valid = 1; m_src = best; m_mask = (bl > 15) ? 15 : bl;
      end
      if (ne) m_np = 1;
      if (de) m_dp = 1;
      m_pn = pin; m_pd = dp;
    end
  end

  always @(negedge clk) begin
    if (model_on) begin
      checks++;
      if (int'(req_valid) != m_valid ||
          (m_valid != 0 && (int'(req_src) != m_src || int'(req_mask) != m_mask))) begin
        errors++;
        $display("FAIL R11 model: act v=%0d src=%0d mask=%0d exp v=%0d src=%0d mask=%0d",
                 req_valid, req_src, req_mask, m_valid, m_src, m_mask);
      end
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act %0d exp %0d", tag, act, exp);
    end
  endtask

  task automatic chk_out(string tag, int v, int s, int m);
    chk(int'(req_valid) == v, {tag, " valid"}, int'(req_valid), v);
    if (v != 0) begin
      chk(int'(req_src) == s, {tag, " src"}, int'(req_src), s);
      chk(int'(req_mask) == m, {tag, " mask"}, int'(req_mask), m);
    end
  endtask

  task automatic do_ack();
    ack = 1'b1; tick(); ack = 1'b0;
  endtask

  initial begin
    tick(3);
    rst = 1'b0; model_on = 1;
    tick();
    chk_out("R1 reset", 0, 0, 0);

    // R12 and R7: external line 1 at level 5 above mask 3
    irq_prio[1*4 +: 4] = 4'd5; irq_req[1] = 1'b1; cur_mask = 4'd3;
    tick();
    chk_out("R12 R7 irq1", 1, 4, 5);
    irq_req[1] = 1'b0; tick();
    chk_out("R11 held after withdraw", 1, 4, 5);
    do_ack();
    chk_out("R11 ack clears", 0, 0, 0);

    // R2: level equal to the mask, and level 0 with mask 0
    cur_mask = 4'd5; irq_req[1] = 1'b1; tick(2);
    chk_out("R2 equal level", 0, 0, 0);
    irq_prio[1*4 +: 4] = 4'd0; cur_mask = 4'd0; tick(2);
    chk_out("R2 level zero", 0, 0, 0);
    irq_req[1] = 1'b0;

    // R8: highest of three levels wins (peripheral 2 is id 9)
    irq_prio[0*4 +: 4] = 4'd3; per_prio[2*4 +: 4] = 4'd9; irq_prio[3*4 +: 4] = 4'd7;
    irq_req[0] = 1'b1; per_req[2] = 1'b1; irq_req[3] = 1'b1;
    tick();
    chk_out("R8 highest", 1, 9, 9);
    irq_req = '0; per_req = '0; do_ack(); tick();

    // R9: tie at level 6 across classes goes to the lowest id
    irq_prio[2*4 +: 4] = 4'd6; per_prio[0*4 +: 4] = 4'd6; irq_prio[1*4 +: 4] = 4'd6;
    irq_req[2] = 1'b1; per_req[0] = 1'b1; irq_req[1] = 1'b1;
    tick();
    chk_out("R9 tie", 1, 4, 6);
    irq_req = '0; per_req = '0; do_ack(); tick();

    // R9, R5, R10, R6: break and debug tie at 15, debug survives the break ack
    dbg_req = 1'b1; ubrk_req = 1'b1; tick();
    chk_out("R9 R5 break first", 1, 1, 15);
    ubrk_req = 1'b0; do_ack();
    chk_out("R10 after break ack", 0, 0, 0);
    tick();
    chk_out("R10 R6 debug kept", 1, 2, 15);
    dbg_req = 1'b0; do_ack(); tick(2);
    chk_out("R10 debug cleared", 0, 0, 0);

    // R6: debug held back by mask 15, accepted once the mask drops
    cur_mask = 4'd15; dbg_req = 1'b1; tick(); dbg_req = 1'b0; tick(3);
    chk_out("R6 masked", 0, 0, 0);
    cur_mask = 4'd14; tick();
    chk_out("R6 released", 1, 2, 15);
    do_ack(); tick();

    // R5: break blocked by mask 15
    cur_mask = 4'd15; ubrk_req = 1'b1; tick(2);
    chk_out("R5 masked", 0, 0, 0);
    ubrk_req = 1'b0;

    // R3, R4, R12: rising-edge NMI through mask 15
    nmi_rise_sel = 1'b1; nmi_pin = 1'b1; tick();
    chk_out("R12 nmi one edge", 0, 0, 0);
    tick();
    chk_out("R3 nmi at mask 15", 1, 0, 15);
    do_ack();
    nmi_pin = 1'b0; tick(3);
    chk_out("R4 falling ignored", 0, 0, 0);
    nmi_rise_sel = 1'b0; nmi_pin = 1'b1; tick(3);
    chk_out("R4 rising ignored", 0, 0, 0);
    nmi_pin = 1'b0; tick(2);
    chk_out("R4 falling taken", 1, 0, 15);
    do_ack(); tick();

    // R10: NMI latched during another source survives that source's ack
    cur_mask = 4'd0; irq_prio[0*4 +: 4] = 4'd2; irq_req[0] = 1'b1; tick();
    chk_out("R10 irq0 up", 1, 3, 2);
    nmi_pin = 1'b1; tick(); nmi_pin = 1'b0; tick();
    irq_req[0] = 1'b0; do_ack(); tick();
    chk_out("R10 nmi kept", 1, 0, 15);
    do_ack(); tick(2);
    chk_out("R10 nmi cleared", 0, 0, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog: act timeout exp finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule